// File: doc/BRIEF.md
# GPIO Port Output Access Logic

This block keeps the output data, the per-pin mask and the per-pin direction of one 16-pin general purpose I/O port. A CPU changes them through a simple single-cycle register bus. The output latch can be written in several atomic ways: a plain whole-port load; write-one-to-set, write-one-to-clear and write-one-to-toggle strobes; and a load that only reaches pins whose mask bit is 0. There are also two per-pin alias windows. One gives single-bit access to a pin. The other gives word access, where a write OR-reduces the data onto the pin and a read replicates the pin level into a full word.

Pin levels come back through a two-flop synchronizer. They are readable as a raw port value whatever the direction, through the masked alias, and through the per-pin windows. Each pin's output driver is enabled by the inverse of its direction bit. A bus write takes effect at the next clock edge. A read is combinational from the registered state.

Byte addresses (bus_addr carries bits 7:2): 0x00 port load, 0x04 set, 0x08 clear, 0x0C masked load, 0x10 toggle, 0x14 raw pin read, 0x18 mask, 0x1C direction, 0x40+4*i bit window of pin i, 0x80+4*i word window of pin i.

Top module: `gpio_port_out`

## Requirements
- R1: After a synchronous active-low reset, pin_out is 0, mask and direction are 0, and pin_oe is all ones.
- R2: A write to 0x00 loads bus_wdata into all 16 output bits. A read of 0x00 returns the output latch.
- R3: A write to 0x04 drives high every pin whose data bit is 1 and leaves the others unchanged.
- R4: A write to 0x08 drives low every pin whose data bit is 1 and leaves the others unchanged.
- R5: A write to 0x10 inverts every pin whose data bit is 1 and leaves the others unchanged.
- R6: A write to 0x0C loads data only into pins whose mask bit (register 0x18, read-write, 1 = masked) is 0. Masked pins keep their value.
- R7: A read of 0x0C returns the synchronized pin levels of unmasked pins, with masked pins reading 0.
- R8: A read of 0x14 returns the synchronized pin levels regardless of direction. A pin change is visible after two clock edges.
- R9: A write to 0x40+4*i sets output bit i from data bit 0, with no other pin changed. A read returns the synchronized level of pin i in bit 0, with the other bits 0.
- R10: A write to 0x80+4*i sets output bit i to the OR of all 16 data bits, with no other pin changed. A read returns the synchronized level of pin i copied into bits 15:0.
- R11: Register 0x1C holds one direction bit per pin (0 = output, 1 = input). It reads back, and pin_oe equals its inverse one edge after a write.
- R12: Reads of the write-only set, clear and toggle addresses and of unused addresses return 0. rdata bits 31:16 are always 0. Cycles without a bus write, and writes to unused addresses, leave pin_out unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address bits 7:2 |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| pin_in | input | 16 | Pad input levels (asynchronous) |
| pin_out | output | 16 | Output latch |
| pin_oe | output | 16 | Output driver enable, 1 = drive |

## Verification
Every write result (pin_out, pin_oe, readable mask and direction) is due one clock edge after the write cycle. The bench holds each write over one rising edge and compares at the following falling edge. Register read-back is combinational, so reads are sampled 2 ns after the address is applied, before any edge. Pin levels need two rising edges through the synchronizer. After changing pin_in the bench waits two falling edges before reading the raw, masked or per-pin windows.

// File: rtl/gpio_port_pkg.sv
// Package: shared constants and types for the GPIO port output access block.
// Assumes byte addresses of 8 bits with word-aligned registers.
package gpio_port_pkg;
    localparam int ADDR_W = 8;

    // Byte offsets of the fixed registers.
    localparam logic [ADDR_W-1:0] OFS_LOAD  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_SET   = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_CLR   = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_MLOAD = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_TOG   = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_RAW   = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_MASK  = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_DIR   = 8'h1C;

    // Region codes in address bits 7:6.
    localparam logic [1:0] REG_FIXED = 2'b00;
    localparam logic [1:0] REG_BIT   = 2'b01;
    localparam logic [1:0] REG_WORD  = 2'b10;

    typedef enum logic [3:0] {
        RS_NONE, RS_LOAD, RS_MLOAD, RS_RAW, RS_MASK, RS_DIR, RS_BIT, RS_WORD
    } rsel_e;

    typedef struct packed {
        logic load;
        logic set;
        logic clr;
        logic tog;
        logic mload;
        logic mask;
        logic dir;
        logic bitw;
        logic wordw;
    } wstb_t;
endpackage

// File: rtl/gpio_port_decode.sv
// Module: address decoder. Turns one bus cycle into one-hot write strobes,
// a read selector and a pin index for the per-pin windows.
// Assumes PORT_W <= 16, so the pin index fits address bits 5:2.
module gpio_port_decode
    import gpio_port_pkg::*;
#(
    parameter int PORT_W = 16,
    localparam int PIDX_W = $clog2(PORT_W)
) (
    input  logic                 sel,
    input  logic                 wr,
    input  logic [ADDR_W-1:2]    addr,
    output wstb_t                wstb,
    output rsel_e                rsel,
    output logic [PIDX_W-1:0]    pin_idx
);
    logic [1:0] region;
    logic [3:0] slot;

    assign region  = addr[ADDR_W-1:ADDR_W-2];
    assign slot    = addr[5:2];
    assign pin_idx = addr[PIDX_W+1:2];

    // Decode region and slot into a strobe set and read selector.
    always_comb begin
        wstb = '0;
        rsel = RS_NONE;
        if (sel) begin
            unique case (region)
                REG_FIXED: begin
                    unique case (slot)
                        OFS_LOAD[5:2]:  begin wstb.load  = wr; rsel = RS_LOAD;  end
                        OFS_SET[5:2]:   wstb.set   = wr;
                        OFS_CLR[5:2]:   wstb.clr   = wr;
                        OFS_MLOAD[5:2]: begin wstb.mload = wr; rsel = RS_MLOAD; end
                        OFS_TOG[5:2]:   wstb.tog   = wr;
                        OFS_RAW[5:2]:   rsel = RS_RAW;
                        OFS_MASK[5:2]:  begin wstb.mask  = wr; rsel = RS_MASK;  end
                        OFS_DIR[5:2]:   begin wstb.dir   = wr; rsel = RS_DIR;   end
                        default:        rsel = RS_NONE;
                    endcase
                end
                REG_BIT:  begin wstb.bitw  = wr; rsel = RS_BIT;  end
                REG_WORD: begin wstb.wordw = wr; rsel = RS_WORD; end
                default:  rsel = RS_NONE;
            endcase
        end
    end
endmodule

// File: rtl/gpio_port_regs.sv
// Module: output latch, mask and direction registers. Applies exactly one
// update per cycle as chosen by the decoder's one-hot strobes.
// Assumes synchronous active-low reset; all state resets to 0.
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int PORT_W = 16,
    localparam int PIDX_W = $clog2(PORT_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  wstb_t              wstb,
    input  logic [PIDX_W-1:0]  pin_idx,
    input  logic [PORT_W-1:0]  wdata,
    output logic [PORT_W-1:0]  out_q,
    output logic [PORT_W-1:0]  mask_q,
    output logic [PORT_W-1:0]  dir_q
);
    logic [PORT_W-1:0] out_nx;
    logic              one_bit;

    // Value a per-pin window write puts on the selected pin.
    assign one_bit = wstb.wordw ? (|wdata) : wdata[0];

    // Next output latch value for each kind of write.
    always_comb begin
        out_nx = out_q;
        if (wstb.load)  out_nx = wdata;
        if (wstb.set)   out_nx = out_q | wdata;
        if (wstb.clr)   out_nx = out_q & ~wdata;
        if (wstb.tog)   out_nx = out_q ^ wdata;
        if (wstb.mload) out_nx = (out_q & mask_q) | (wdata & ~mask_q);
        if (wstb.bitw || wstb.wordw) out_nx[pin_idx] = one_bit;
    end

    // Output latch register.
    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_nx;
    end

    // Mask register, 1 protects a pin from masked loads.
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_q <= '0;
        else if (wstb.mask) mask_q <= wdata;
    end

    // Direction register, 1 = input.
    always_ff @(posedge clk) begin
        if (!rst_n)        dir_q <= '0;
        else if (wstb.dir) dir_q <= wdata;
    end
endmodule

// File: rtl/gpio_port_sync.sv
// Module: multi-flop synchronizer for the pad inputs.
// Assumes each pin is an independent asynchronous level; no bus coherency.
module gpio_port_sync #(
    parameter int PORT_W = 16,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] d,
    output logic [PORT_W-1:0] q
);
    logic [PORT_W-1:0] stage [STAGES];

    // First flop samples the asynchronous pads.
    always_ff @(posedge clk) begin
        if (!rst_n) stage[0] <= '0;
        else        stage[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Each later flop re-samples the previous one.
        always_ff @(posedge clk) begin
            if (!rst_n) stage[s] <= '0;
            else        stage[s] <= stage[s-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_port_readmux.sv
// Module: read-back multiplexer. Purely combinational from registered state.
// Assumes DATA_W >= PORT_W; unused upper bits read 0.
module gpio_port_readmux
    import gpio_port_pkg::*;
#(
    parameter int PORT_W = 16,
    parameter int DATA_W = 32,
    localparam int PIDX_W = $clog2(PORT_W)
) (
    input  rsel_e              rsel,
    input  logic [PIDX_W-1:0]  pin_idx,
    input  logic [PORT_W-1:0]  out_q,
    input  logic [PORT_W-1:0]  mask_q,
    input  logic [PORT_W-1:0]  dir_q,
    input  logic [PORT_W-1:0]  pins_s,
    output logic [DATA_W-1:0]  rdata
);
    logic [PORT_W-1:0] sel_val;

    // Pick the port-wide value for the selected read target.
    always_comb begin
        unique case (rsel)
            RS_LOAD:  sel_val = out_q;
            RS_MLOAD: sel_val = pins_s & ~mask_q;
            RS_RAW:   sel_val = pins_s;
            RS_MASK:  sel_val = mask_q;
            RS_DIR:   sel_val = dir_q;
            RS_BIT:   sel_val = {{(PORT_W-1){1'b0}}, pins_s[pin_idx]};
            RS_WORD:  sel_val = {PORT_W{pins_s[pin_idx]}};
            default:  sel_val = '0;
        endcase
    end

    assign rdata = {{(DATA_W-PORT_W){1'b0}}, sel_val};
endmodule

// File: rtl/gpio_port_out.sv
// Module: top of the GPIO port output access block. Wires decoder, registers,
// input synchronizer and read mux. Output enable is the inverse of direction.
// Assumes a single-cycle bus: writes commit at the next edge, reads are combinational.
module gpio_port_out
    import gpio_port_pkg::*;
#(
    parameter int PORT_W = 16,
    parameter int DATA_W = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:2]    bus_addr,
    input  logic [PORT_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [PORT_W-1:0]    pin_in,
    output logic [PORT_W-1:0]    pin_out,
    output logic [PORT_W-1:0]    pin_oe
);
    localparam int PIDX_W = $clog2(PORT_W);

    wstb_t             wstb;
    rsel_e             rsel;
    logic [PIDX_W-1:0] pin_idx;
    logic [PORT_W-1:0] mask_q;
    logic [PORT_W-1:0] dir_q;
    logic [PORT_W-1:0] pins_s;

    gpio_port_decode #(.PORT_W(PORT_W)) u_dec (
        .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
        .wstb(wstb), .rsel(rsel), .pin_idx(pin_idx)
    );

    gpio_port_regs #(.PORT_W(PORT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wstb(wstb), .pin_idx(pin_idx),
        .wdata(bus_wdata), .out_q(pin_out), .mask_q(mask_q), .dir_q(dir_q)
    );

    gpio_port_sync #(.PORT_W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pins_s)
    );

    gpio_port_readmux #(.PORT_W(PORT_W), .DATA_W(DATA_W)) u_rmux (
        .rsel(rsel), .pin_idx(pin_idx), .out_q(pin_out), .mask_q(mask_q),
        .dir_q(dir_q), .pins_s(pins_s), .rdata(bus_rdata)
    );

    assign pin_oe = ~dir_q;
endmodule

// File: rtl/gpio_port_out_chk.sv
// Checker: temporal properties of the GPIO port output access block, seen at its ports.
module gpio_port_out_chk
    import gpio_port_pkg::*;
#(
    parameter int PORT_W = 16,
    parameter int DATA_W = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_sel,
    input logic                 bus_wr,
    input logic [ADDR_W-1:2]    bus_addr,
    input logic [PORT_W-1:0]    bus_wdata,
    input logic [DATA_W-1:0]    bus_rdata,
    input logic [PORT_W-1:0]    pin_in,
    input logic [PORT_W-1:0]    pin_out,
    input logic [PORT_W-1:0]    pin_oe
);
    logic       wr_cyc;
    logic [1:0] warm_cnt;

    assign wr_cyc = bus_sel && bus_wr;

    // Count edges since reset so the synchronizer check starts only when primed.
    always_ff @(posedge clk) begin
        if (!rst_n)             warm_cnt <= '0;
        else if (warm_cnt != 2) warm_cnt <= warm_cnt + 2'd1;
    end

    // R2
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cyc && bus_addr == OFS_LOAD[7:2]) |=> pin_out == $past(bus_wdata));

    // R3
    set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cyc && bus_addr == OFS_SET[7:2]) |=> pin_out == ($past(pin_out) | $past(bus_wdata)));

    // R4
    clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cyc && bus_addr == OFS_CLR[7:2]) |=> pin_out == ($past(pin_out) & ~$past(bus_wdata)));

    // R5
    tog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cyc && bus_addr == OFS_TOG[7:2]) |=> pin_out == ($past(pin_out) ^ $past(bus_wdata)));

    // R11
    dir_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cyc && bus_addr == OFS_DIR[7:2]) |=> pin_oe == ~$past(bus_wdata));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_cyc |=> $stable(pin_out));

    // R12
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:PORT_W] == '0);

    // R8
    raw_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_cnt == 2 && bus_sel && !bus_wr && bus_addr == OFS_RAW[7:2])
            |-> bus_rdata[PORT_W-1:0] == $past(pin_in, 2));
endmodule

bind gpio_port_out gpio_port_out_chk #(.PORT_W(PORT_W), .DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/gpio_port_out_tb_top.sv
module gpio_port_out_tb_top;
    localparam int PW = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:2]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out;
    logic [15:0] pin_oe;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    // Bench model state.
    logic [15:0] m_out = '0, m_mask = '0, m_dir = '0, m_pins = '0;

    always #10 clk = ~clk;

    gpio_port_out dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Model of the latch after a write at byte address a.
    function automatic logic [15:0] f_next(input logic [7:0] a, input logic [15:0] w);
        logic [15:0] q = m_out;
        if (a[7:6] == 2'b01)       q[a[5:2]] = w[0];
        else if (a[7:6] == 2'b10)  q[a[5:2]] = |w;
        else case (a)
            8'h00: q = w;
            8'h04: q = m_out | w;
            8'h08: q = m_out & ~w;
            8'h0C: q = (m_out & m_mask) | (w & ~m_mask);
            8'h10: q = m_out ^ w;
            default: ;
        endcase
        return q;
    endfunction

    // Model of the read data at byte address a.
    function automatic logic [31:0] f_read(input logic [7:0] a);
        logic [15:0] v = '0;
        if (a[7:6] == 2'b01)       v = {15'd0, m_pins[a[5:2]]};
        else if (a[7:6] == 2'b10)  v = {16{m_pins[a[5:2]]}};
        else case (a)
            8'h00: v = m_out;
            8'h0C: v = m_pins & ~m_mask;
            8'h14: v = m_pins;
            8'h18: v = m_mask;
            8'h1C: v = m_dir;
            default: v = '0;
        endcase
        return {16'd0, v};
    endfunction

    function automatic string f_tag(input logic [7:0] a);
        if (a[7:6] == 2'b01) return "R9";
        if (a[7:6] == 2'b10) return "R10";
        case (a)
            8'h00: return "R2";
            8'h04: return "R3";
            8'h08: return "R4";
            8'h0C: return "R6";
            8'h10: return "R5";
            8'h18: return "R6";
            8'h1C: return "R11";
            default: return "R12";
        endcase
    endfunction

    // Write: drive at a falling edge, hold over one rising edge, check after it.
    task automatic bus_write(input logic [7:0] a, input logic [15:0] w);
        logic [15:0] exp_out = f_next(a, w);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a[7:2]; bus_wdata = w;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        m_out = exp_out;
        if (a == 8'h18) m_mask = w;
        if (a == 8'h1C) m_dir = w;
        chk({f_tag(a), " pin_out"}, {16'd0, pin_out}, {16'd0, m_out});
        chk("R11 pin_oe", {16'd0, pin_oe}, {16'd0, ~m_dir});
    endtask

    // Read: combinational, sampled 2 ns after the address is applied.
    task automatic bus_read(input logic [7:0] a, input string tag);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a[7:2];
        #2;
        chk(tag, bus_rdata, f_read(a));
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    // Change pads and let two rising edges pass through the synchronizer.
    task automatic drive_pins(input logic [15:0] v);
        pin_in = v;
        @(negedge clk);
        @(negedge clk);
        m_pins = v;
    endtask

    initial begin
        void'($urandom(32'h5EED_0011));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 pin_out", {16'd0, pin_out}, 32'd0);
        chk("R1 pin_oe", {16'd0, pin_oe}, 32'h0000_FFFF);
        bus_read(8'h00, "R1 load readback");
        bus_read(8'h18, "R1 mask readback");
        bus_read(8'h1C, "R1 dir readback");

        // Directed corners.
        bus_write(8'h00, 16'hA5C3);                 // R2
        bus_read(8'h00, "R2 load readback");
        bus_write(8'h04, 16'h0000);                 // R3 zero has no effect
        bus_write(8'h04, 16'h0F0F);                 // R3
        bus_write(8'h08, 16'hFFFF);                 // R4 all cleared
        bus_write(8'h10, 16'h8001);                 // R5
        bus_write(8'h18, 16'hFF00);                 // R6 mask upper byte
        bus_read(8'h18, "R6 mask readback");
        bus_write(8'h0C, 16'hFFFF);                 // R6 only low byte loads
        bus_write(8'h40 + 8'd4 * 8'd9, 16'hFFFE);   // R9 bit0=0 clears pin 9
        bus_write(8'h40 + 8'd4 * 8'd3, 16'h0001);   // R9 sets pin 3
        bus_write(8'h80 + 8'd4 * 8'd15, 16'h0000);  // R10 all zero gives 0
        bus_write(8'h80 + 8'd4 * 8'd12, 16'h4000);  // R10 any one gives 1
        bus_write(8'h1C, 16'h00FF);                 // R11
        bus_read(8'h1C, "R11 dir readback");
        drive_pins(16'hC3A5);
        bus_read(8'h14, "R8 raw read with mixed direction");
        bus_read(8'h0C, "R7 masked read");
        bus_read(8'h40 + 8'd4 * 8'd0, "R9 bit read pin0");
        bus_read(8'h40 + 8'd4 * 8'd1, "R9 bit read pin1");
        bus_read(8'h80 + 8'd4 * 8'd15, "R10 word read pin15");
        bus_read(8'h80 + 8'd4 * 8'd3, "R10 word read pin3");
        bus_read(8'h04, "R12 set reads 0");
        bus_read(8'h08, "R12 clear reads 0");
        bus_read(8'h10, "R12 toggle reads 0");
        bus_read(8'hC4, "R12 unused reads 0");
        bus_write(8'hC4, 16'hFFFF);                 // R12 unused write
        // R12 write strobe without select
        bus_wr = 1'b1; bus_addr = 6'd0; bus_wdata = 16'h1234;
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R12 no select", {16'd0, pin_out}, {16'd0, m_out});
        // R8 two-edge latency: after one edge the old level still reads
        pin_in = 16'h0FF0;
        @(negedge clk);
        bus_read(8'h14, "R8 one edge old value");
        m_pins = 16'h0FF0;
        bus_read(8'h14, "R8 two edges new value");

        // Constrained random mix.
        for (int n = 0; n < 400; n++) begin
            int op = $urandom_range(0, 11);
            logic [15:0] w = 16'($urandom);
            logic [7:0] idx = 8'($urandom_range(0, 15));
            case (op)
                0: bus_write(8'h00, w);
                1: bus_write(8'h04, w);
                2: bus_write(8'h08, w);
                3: bus_write(8'h10, w);
                4: bus_write(8'h0C, w);
                5: bus_write(8'h18, w);
                6: bus_write(8'h1C, w);
                7: bus_write(8'h40 + 8'd4 * idx, w);
                8: bus_write(8'h80 + 8'd4 * idx, ($urandom_range(0, 1) == 1) ? w : 16'h0);
                9: begin
                    drive_pins(w);
                    bus_read(8'h14, "R8 random raw");
                    bus_read(8'h0C, "R7 random masked");
                end
                10: begin
                    bus_read(8'h40 + 8'd4 * idx, "R9 random bit read");
                    bus_read(8'h80 + 8'd4 * idx, "R10 random word read");
                end
                default: bus_read(8'h00, "R2 random load readback");
            endcase
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule